// File: doc/BRIEF.md
# Power-Good Reset Sequencer with Strap Capture

This block turns a raw power-good input and a free-running reference clock into an active-low system reset. A power-good rise is first synchronised through two flops. It is then checked for a minimum high width before a reset hold period starts. The hold length is requested on a plain input and clamped into a window. The lower edge of the window is one millisecond and the upper edge is ten milliseconds. Both edges are derived from a clock-frequency parameter given in kHz. A request above the upper edge raises a clip flag.

Any fall of power-good asserts reset at once, without waiting for a clock. It returns the sequence to its idle state, so the next rise always earns a complete filter and hold. Reset is released on a clock edge. The driver enable for the bus-agent outputs follows reset one clock later.

On the release edge a word of configuration straps is latched and marked valid. The word is a held value rather than a stream. It has no ready signal and exerts no back-pressure: it stays constant until power-good next falls, and then it and its valid flag clear.

Top module: `pwr_rst_seq`

## Requirements
- R1: While `pg_in` is low, `rst_n_o`, `drv_oe`, `cfg_vld`, `hold_clip` and `cfg_word` are all 0, and they go to 0 as soon as `pg_in` falls, with no clock edge needed.
- R2: After `pg_in` rises (with no intervening fall), `rst_n_o` goes high on clock edge number 3 + PG_CYC + L, counting the first rising edge after the rise of `pg_in` as edge 1. PG_CYC = max(1, CLK_KHZ*PG_MIN_US/1000), and L is the effective hold.
- R3: The effective hold L is `hold_req` clamped to the range MIN_CYC = CLK_KHZ to MAX_CYC = 10*CLK_KHZ.
- R4: `hold_clip` is 1 when `hold_req` exceeded MAX_CYC at the start of the hold. It stays 1 until `pg_in` falls, and is 0 for any request at or below MAX_CYC.
- R5: A fall of `pg_in` during the filter or the hold restarts the sequence. Release then follows the R2 timing measured from the new rise.
- R6: A power-good high pulse that ends before the filter completes leaves `rst_n_o` low throughout. The following rise receives the full R2 timing.
- R7: `drv_oe` is 0 on any clock edge that follows an edge at which `rst_n_o` was low. It goes to 1 one clock edge after `rst_n_o` rises.
- R8: On the edge where `rst_n_o` rises, `cfg_word` takes the value of `strap_in` and `cfg_vld` goes to 1. Later changes of `strap_in` leave `cfg_word` unchanged while reset stays released.
- R9: `cfg_vld` equals `rst_n_o` at every clock edge, and `cfg_word` is 0 whenever `cfg_vld` is 0.
- R10: `hold_req` is sampled once, at the start of the hold. Changes to it during the hold do not alter the release edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| pg_in | input | 1 | Raw power-good level; low clears the block asynchronously |
| hold_req | input | CNT_W | Requested reset hold length in clock cycles |
| strap_in | input | STRAP_W | Configuration strap levels |
| rst_n_o | output | 1 | Active-low system reset |
| drv_oe | output | 1 | Output enable for the bus-agent drivers |
| cfg_word | output | STRAP_W | Strap word captured at reset release |
| cfg_vld | output | 1 | Captured strap word is valid |
| hold_clip | output | 1 | Requested hold exceeded the upper bound and was clamped |

## Verification
Release is due on edge 3 + PG_CYC + L after the power-good rise. This figure comes from two synchroniser flops, one cycle to enter the filter, PG_CYC filter cycles and L hold cycles. The bench counts rising edges from the rise and samples at each following falling edge, so the first edge at which reset reads high is compared against that figure. The strap word and the clip flag are due on that same edge. The driver enable is due exactly one edge later, and the bench samples it at both points. The asynchronous clear needs no edge, so it is sampled a short delay after power-good falls.

// File: rtl/pwr_rst_pkg.sv
package pwr_rst_pkg;
  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_FILTER = 2'd1,
    ST_HOLD   = 2'd2,
    ST_RUN    = 2'd3
  } seq_state_t;
endpackage

// File: rtl/pg_sync.sv
module pg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic pg_in,
  output logic pg_s
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge pg_in) begin
    if (!pg_in) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign pg_s = sh_q[STAGES-1];
endmodule

// File: rtl/seq_fsm.sv
module seq_fsm
  import pwr_rst_pkg::*;
#(
  parameter int PG_CYC  = 4,
  parameter int MIN_CYC = 4,
  parameter int MAX_CYC = 40,
  parameter int CNT_W   = 8
) (
  input  logic             clk,
  input  logic             pg_in,
  input  logic             pg_s,
  input  logic [CNT_W-1:0] hold_req,
  output logic             rst_n_q,
  output logic             rel_pulse,
  output logic             clip_q
);
  localparam logic [CNT_W-1:0] PG_LAST = CNT_W'(PG_CYC - 1);
  localparam logic [CNT_W-1:0] LIM_LO  = CNT_W'(MIN_CYC);
  localparam logic [CNT_W-1:0] LIM_HI  = CNT_W'(MAX_CYC);

  seq_state_t       st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d, lim_q, lim_d;
  logic             clip_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    lim_d  = lim_q;
    clip_d = clip_q;
    unique case (st_q)
      ST_OFF: if (pg_s) begin
        st_d  = ST_FILTER;
        cnt_d = '0;
      end
      ST_FILTER: if (cnt_q == PG_LAST) begin
        st_d   = ST_HOLD;
        cnt_d  = '0;
        lim_d  = (hold_req < LIM_LO) ? LIM_LO :
                 (hold_req > LIM_HI) ? LIM_HI : hold_req;
        clip_d = (hold_req > LIM_HI);
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
      ST_HOLD: if (cnt_q == lim_q - 1'b1) st_d = ST_RUN;
               else                         cnt_d = cnt_q + 1'b1;
      default: ;
    endcase
    if (!pg_s) st_d = ST_OFF;
  end

  assign rel_pulse = (st_d == ST_RUN) && (st_q != ST_RUN);

  always_ff @(posedge clk or negedge pg_in) begin
    if (!pg_in) begin
      st_q    <= ST_OFF;
      cnt_q   <= '0;
      lim_q   <= LIM_LO;
      clip_q  <= 1'b0;
      rst_n_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      lim_q   <= lim_d;
      clip_q  <= clip_d;
      rst_n_q <= (st_d == ST_RUN);
    end
  end

  a_r3_lim_in_window: assert property (@(posedge clk) disable iff (!pg_in)
    (st_q == ST_HOLD) |-> (lim_q >= LIM_LO && lim_q <= LIM_HI));
  a_r4_clip_at_top: assert property (@(posedge clk) disable iff (!pg_in)
    clip_q |-> (lim_q == LIM_HI));
  a_r2_release_from_hold: assert property (@(posedge clk) disable iff (!pg_in)
    $rose(rst_n_q) |-> ($past(st_q) == ST_HOLD));
endmodule

// File: rtl/strap_latch.sv
module strap_latch #(
  parameter int STRAP_W = 8
) (
  input  logic               clk,
  input  logic               pg_in,
  input  logic               cap,
  input  logic [STRAP_W-1:0] strap_in,
  output logic [STRAP_W-1:0] word_q,
  output logic               vld_q
);
  always_ff @(posedge clk or negedge pg_in) begin
    if (!pg_in) begin
      word_q <= '0;
      vld_q  <= 1'b0;
    end else if (cap) begin
      word_q <= strap_in;
      vld_q  <= 1'b1;
    end
  end

  a_r8_word_stable: assert property (@(posedge clk) disable iff (!pg_in)
    (vld_q && $past(vld_q)) |-> $stable(word_q));
endmodule

// File: rtl/pwr_rst_seq.sv
module pwr_rst_seq #(
  parameter int CLK_KHZ   = 250000,
  parameter int PG_MIN_US = 100,
  parameter int CNT_W     = 24,
  parameter int STRAP_W   = 16
) (
  input  logic               clk,
  input  logic               pg_in,
  input  logic [CNT_W-1:0]   hold_req,
  input  logic [STRAP_W-1:0] strap_in,
  output logic               rst_n_o,
  output logic               drv_oe,
  output logic [STRAP_W-1:0] cfg_word,
  output logic               cfg_vld,
  output logic               hold_clip
);
  localparam int PG_RAW  = (CLK_KHZ * PG_MIN_US) / 1000;
  localparam int PG_CYC  = (PG_RAW < 1) ? 1 : PG_RAW;
  localparam int MIN_CYC = CLK_KHZ;
  localparam int MAX_CYC = 10 * CLK_KHZ;

  logic pg_s, rel_pulse, oe_q;

  pg_sync #(.STAGES(2)) u_sync (
    .clk(clk), .pg_in(pg_in), .pg_s(pg_s)
  );

  seq_fsm #(
    .PG_CYC(PG_CYC), .MIN_CYC(MIN_CYC), .MAX_CYC(MAX_CYC), .CNT_W(CNT_W)
  ) u_fsm (
    .clk(clk), .pg_in(pg_in), .pg_s(pg_s), .hold_req(hold_req),
    .rst_n_q(rst_n_o), .rel_pulse(rel_pulse), .clip_q(hold_clip)
  );

  strap_latch #(.STRAP_W(STRAP_W)) u_strap (
    .clk(clk), .pg_in(pg_in), .cap(rel_pulse), .strap_in(strap_in),
    .word_q(cfg_word), .vld_q(cfg_vld)
  );

  always_ff @(posedge clk or negedge pg_in) begin
    if (!pg_in) oe_q <= 1'b0;
    else        oe_q <= rst_n_o;
  end
  assign drv_oe = oe_q;

  a_r7_oe_off: assert property (@(posedge clk) disable iff (!pg_in)
    !rst_n_o |=> !drv_oe);
  a_r9_vld_follows_rst: assert property (@(posedge clk) disable iff (!pg_in)
    cfg_vld == rst_n_o);
  a_r9_word_zero: assert property (@(posedge clk) disable iff (!pg_in)
    !cfg_vld |-> (cfg_word == '0));
endmodule

// File: tb/pwr_rst_seq_tb.sv
module pwr_rst_seq_tb;
  localparam int CNT_W = 8;
  localparam int SW    = 8;

  logic clk = 1'b0;
  logic pg_in = 1'b0;
  logic [CNT_W-1:0] hold_req = '0;
  logic [SW-1:0] strap_in = '0;
  logic rst_n_o, drv_oe, cfg_vld, hold_clip;
  logic [SW-1:0] cfg_word;
  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  pwr_rst_seq #(.CLK_KHZ(4), .PG_MIN_US(750), .CNT_W(CNT_W), .STRAP_W(SW)) u_dut (
    .clk(clk), .pg_in(pg_in), .hold_req(hold_req), .strap_in(strap_in),
    .rst_n_o(rst_n_o), .drv_oe(drv_oe), .cfg_word(cfg_word),
    .cfg_vld(cfg_vld), .hold_clip(hold_clip)
  );

  // {hold_req, strap, release edge, clip}; PG_CYC=3, window 4..40
  localparam int VEC [6][4] = '{
    '{6,   'hA5, 12, 0},
    '{1,   'h3C, 10, 0},
    '{4,   'h0F,  10, 0},
    '{40,  'hF0, 46, 0},
    '{41,  'h81, 46, 1},
    '{200, 'h7E, 46, 1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic edges_to_release(output int n);
    n = 0;
    for (int i = 1; i <= 100; i++) begin
      @(posedge clk); @(negedge clk);
      if (rst_n_o) begin n = i; break; end
    end
  endtask

  task automatic pg_low(input int cyc);
    pg_in = 1'b0;
    repeat (cyc) @(negedge clk);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 rst_n", rst_n_o, 0);
    chk("R1 drv_oe", drv_oe, 0);
    chk("R1 cfg_vld", cfg_vld, 0);
    chk("R1 cfg_word", cfg_word, 0);
    chk("R1 hold_clip", hold_clip, 0);

    // Vector table: R2, R3, R4, R7, R8
    for (int v = 0; v < 6; v++) begin
      pg_low(2);
      hold_req = CNT_W'(VEC[v][0]);
      strap_in = SW'(VEC[v][1]);
      pg_in = 1'b1;
      edges_to_release(n);
      chk("R2 R3 release edge", n, VEC[v][2]);
      chk("R4 hold_clip", hold_clip, VEC[v][3]);
      chk("R8 cfg_word", cfg_word, VEC[v][1]);
      chk("R8 cfg_vld", cfg_vld, 1);
      chk("R7 oe still low", drv_oe, 0);
      @(negedge clk);
      chk("R7 oe one edge later", drv_oe, 1);
    end

    // R8: strap changes while running are ignored
    strap_in = 8'h11;
    repeat (3) @(negedge clk);
    chk("R8 word held", cfg_word, 8'h7E);

    // R1, R7, R9: drop from run
    pg_in = 1'b0;
    #1;
    chk("R1 async rst_n", rst_n_o, 0);
    chk("R7 async oe", drv_oe, 0);
    @(negedge clk); @(negedge clk);
    chk("R7 oe within two", drv_oe, 0);
    chk("R9 cfg_vld clear", cfg_vld, 0);
    chk("R9 cfg_word clear", cfg_word, 0);
    chk("R4 clip clear", hold_clip, 0);

    // R10: hold request changed mid-hold
    pg_low(2);
    hold_req = 8'd6;
    pg_in = 1'b1;
    repeat (8) @(negedge clk);
    hold_req = 8'd30;
    edges_to_release(n);
    chk("R10 release edge", n + 8, 12);

    // R5: drop mid-hold, restart
    pg_low(2);
    hold_req = 8'd6;
    pg_in = 1'b1;
    repeat (9) @(negedge clk);
    chk("R5 still in reset", rst_n_o, 0);
    pg_low(1);
    chk("R5 reset after drop", rst_n_o, 0);
    pg_in = 1'b1;
    edges_to_release(n);
    chk("R5 full restart", n, 12);

    // R6: short glitch rejected, then full sequence
    pg_low(2);
    pg_in = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 glitch rst_n", rst_n_o, 0);
    pg_low(1);
    chk("R6 after glitch", rst_n_o, 0);
    pg_in = 1'b1;
    edges_to_release(n);
    chk("R6 full length", n, 12);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  end
endmodule